// File: doc/BRIEF.md
# Serial EEPROM Host Sequencer

This block is the host side of a three-wire serial EEPROM link. A local client supplies a command code, a word address, sixteen bits of write data and a burst length, then pulses a start strobe. The block builds the serial frame, drives chip select, serial clock and serial data out, and samples the device's serial data line. It finishes with a one-cycle done pulse. Read words come back one at a time on a result bus, each marked with a valid pulse.

Programming commands are write word, erase word, write-all and erase-all. For each of these the block drops chip select to start the device's self-timed cycle. It keeps select low for a set number of clocks, then raises it with data-out held low and polls the device's status bit. Polling ends when the bit reads 1, or when a timeout sets an error flag. The serial clock comes from a divider parameter. Data-out changes only on serial clock falling edges, and the input is sampled in the last system clock before each rising edge.

Top module: `mwh_host`

## Requirements
- R1: While rst_n is low and in the first cycle after it, eep_cs, eep_sk, eep_di, busy, done, err and rd_valid are all 0.
- R2: Every frame is a 1 start bit, a 2-bit opcode and an (AW+1)-bit field. cmd_op values are: 0 read (opcode 10), 1 write (01) and 2 erase (11), each with field {0, address}. The rest use opcode 00 with the top two field bits set and all other field bits 0: 3 enable-writes (11), 4 disable-writes (00), 5 write-all (01), 6 erase-all (10).
- R3: Write and write-all send 16 data bits MSB first right after the field. Select falls on the same clock as the serial clock falls after the last bit, so no further rising edge is seen with select high.
- R4: The serial clock has a period of 2*SK_HALF clocks and starts low. It stays low whenever select is low. Data-out never changes while the serial clock is high.
- R5: A read throws away the first sampled bit (the device's leading 0). It then collects 16 bits MSB first and presents each word on rd_data with a one-cycle rd_valid pulse.
- R6: A read returns cmd_words words (0 counts as 1) from consecutive addresses within one select window. The address after the top one is 0.
- R7: After write, erase, write-all and erase-all, select stays low for at least CS_GAP clocks and is then raised with data-out low. Polling ends when the sampled status bit is 1.
- R8: If POLL_LIMIT status samples all read 0, err is set with done. err then holds until the next accepted command, which clears it.
- R9: done is a single-cycle pulse with select low. busy is high from the cycle after a start is accepted through the done cycle. A start while busy is ignored.
- R10: cmd_op 7 is rejected. done and err=1 follow within two cycles, and select never rises.
- R11: Enable-writes and disable-writes send only the 11-bit header and finish without polling, so there is exactly one select window. A write issued after disable-writes leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start strobe, taken only when idle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data for write and write-all |
| cmd_words | input | WCW | Number of words for a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished, one cycle |
| err | output | 1 | Poll timeout or rejected code |
| rd_data | output | DW | Last word read |
| rd_valid | output | 1 | rd_data updated this cycle |
| eep_cs | output | 1 | Device select |
| eep_sk | output | 1 | Serial clock |
| eep_di | output | 1 | Serial data to device |
| eep_do | input | 1 | Serial data from device |

## Verification
Some rules are checked by properties on every clock. The serial clock must never be high with select low, and data-out must not change while the serial clock is high. Data-out must stay low during polling, and done must be one cycle long with select low. Read results may appear only inside a select window. Frame content, dummy-bit removal, burst wrap, write protection, the select-low gap, the poll timeout and the rejection of code 7 can only be shown by the bench scenarios. These run against a behavioural device model and a shadow copy of memory.

// File: rtl/mwh_pkg.sv
// Shared types for the serial EEPROM host sequencer.
package mwh_pkg;
    // Client command codes; values are part of the interface.
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WEN   = 3'd3,
        OP_WDS   = 3'd4,
        OP_WRALL = 3'd5,
        OP_ERAL  = 3'd6,
        OP_BAD   = 3'd7
    } mwh_op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE, S_SHIFT, S_READ, S_GAP, S_POLL, S_FIN
    } mwh_state_e;
endpackage

// File: rtl/mwh_skgen.sv
// Serial clock divider. While run is high, sk toggles every HALF clocks,
// starting low. rise_en/fall_en mark the clock before each sk edge.
// Assumes run drops only on a fall_en cycle or while sk is low.
module mwh_skgen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk,
    output logic rise_en,
    output logic fall_en
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap    = (cnt == CW'(HALF - 1));
    assign rise_en = run && wrap && !sk;
    assign fall_en = run && wrap && sk;

    // Half-period counter and sk toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sk  <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sk  <= ~sk;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mwh_frame.sv
// Frame builder: maps a command to its serial bit pattern (left aligned),
// its length and its class. Purely combinational.
module mwh_frame
    import mwh_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic [2:0]                           op,
    input  logic [AW-1:0]                        addr,
    input  logic [DW-1:0]                        wdata,
    output logic [AW+4+DW-1:0]                   frame,
    output logic [$clog2(AW+4+DW+1)-1:0]         nbits,
    output logic                                 is_read,
    output logic                                 is_prog
);
    localparam int HW  = AW + 4;
    localparam int FW  = HW + DW;
    localparam int NBW = $clog2(FW + 1);

    logic [HW-1:0] hdr;
    logic          has_data;
    mwh_op_e       opc;

    assign opc = mwh_op_e'(op);

    // Header and class decode per command code.
    always_comb begin
        hdr      = '0;
        has_data = 1'b0;
        is_read  = 1'b0;
        is_prog  = 1'b0;
        case (opc)
            OP_READ:  begin hdr = {3'b110, 1'b0, addr}; is_read = 1'b1; end
            OP_WRITE: begin hdr = {3'b101, 1'b0, addr}; has_data = 1'b1; is_prog = 1'b1; end
            OP_ERASE: begin hdr = {3'b111, 1'b0, addr}; is_prog = 1'b1; end
            OP_WEN:   hdr = {3'b100, 2'b11, {(AW-1){1'b0}}};
            OP_WDS:   hdr = {3'b100, 2'b00, {(AW-1){1'b0}}};
            OP_WRALL: begin hdr = {3'b100, 2'b01, {(AW-1){1'b0}}}; has_data = 1'b1; is_prog = 1'b1; end
            OP_ERAL:  begin hdr = {3'b100, 2'b10, {(AW-1){1'b0}}}; is_prog = 1'b1; end
            default:  hdr = '0;
        endcase
    end

    assign frame = {hdr, has_data ? wdata : {DW{1'b0}}};
    assign nbits = has_data ? NBW'(FW) : NBW'(HW);
endmodule

// File: rtl/mwh_host.sv
// Serial EEPROM host sequencer (top). Takes one command at a time from
// the client, shifts the frame out, collects read bursts, and polls
// status after programming. Assumes the device updates its output on sk
// rising edges and shows ready/busy on its output while selected.
module mwh_host
    import mwh_pkg::*;
#(
    parameter int AW         = 7,
    parameter int DW         = 16,
    parameter int WCW        = 8,
    parameter int SK_HALF    = 4,
    parameter int CS_GAP     = 6,
    parameter int POLL_LIMIT = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_start,
    input  logic [2:0]     cmd_op,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [DW-1:0]  cmd_wdata,
    input  logic [WCW-1:0] cmd_words,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid,
    output logic           eep_cs,
    output logic           eep_sk,
    output logic           eep_di,
    input  logic           eep_do
);
    localparam int HW  = AW + 4;
    localparam int FW  = HW + DW;
    localparam int NBW = $clog2(FW + 1);
    localparam int RBW = $clog2(DW);
    localparam int GW  = $clog2(CS_GAP + 1);
    localparam int PW  = $clog2(POLL_LIMIT + 1);

    mwh_state_e      state;
    logic [FW-1:0]   frame_c, frame_q;
    logic [NBW-1:0]  nbits_c, nbits_q, bitcnt;
    logic            rd_c, prog_c, rd_q, prog_q;
    logic            closing, dummy;
    logic [RBW-1:0]  rbit;
    logic [DW-1:0]   shreg;
    logic [WCW-1:0]  words_left;
    logic [GW-1:0]   gapcnt;
    logic [PW-1:0]   pollcnt;
    logic            run, rise_en, fall_en;

    mwh_frame #(.AW(AW), .DW(DW)) frame_i (
        .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata),
        .frame(frame_c), .nbits(nbits_c), .is_read(rd_c), .is_prog(prog_c)
    );

    assign run = (state == S_SHIFT) || (state == S_READ) || (state == S_POLL);

    mwh_skgen #(.HALF(SK_HALF)) skgen_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sk(eep_sk), .rise_en(rise_en), .fall_en(fall_en)
    );

    assign busy = (state != S_IDLE);
    assign done = (state == S_FIN);

    // Command sequencer: frame shift, read capture, gap, status poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            eep_cs     <= 1'b0;
            eep_di     <= 1'b0;
            err        <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            frame_q    <= '0;
            nbits_q    <= '0;
            rd_q       <= 1'b0;
            prog_q     <= 1'b0;
            bitcnt     <= '0;
            closing    <= 1'b0;
            dummy      <= 1'b0;
            rbit       <= '0;
            shreg      <= '0;
            words_left <= '0;
            gapcnt     <= '0;
            pollcnt    <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_start) begin
                        if (mwh_op_e'(cmd_op) == OP_BAD) begin
                            err   <= 1'b1;
                            state <= S_FIN;
                        end else begin
                            err        <= 1'b0;
                            frame_q    <= frame_c;
                            nbits_q    <= nbits_c;
                            rd_q       <= rd_c;
                            prog_q     <= prog_c;
                            words_left <= (cmd_words == '0) ? WCW'(1) : cmd_words;
                            bitcnt     <= '0;
                            closing    <= 1'b0;
                            eep_cs     <= 1'b1;
                            eep_di     <= frame_c[FW-1];
                            state      <= S_SHIFT;
                        end
                    end
                end
                S_SHIFT: begin
                    if (rise_en && !closing) begin
                        if (bitcnt == nbits_q - NBW'(1)) begin
                            if (rd_q) begin
                                state <= S_READ;
                                dummy <= 1'b1;
                                rbit  <= '0;
                            end else begin
                                closing <= 1'b1;
                            end
                        end else begin
                            bitcnt <= bitcnt + NBW'(1);
                        end
                    end
                    if (fall_en) begin
                        if (closing) begin
                            eep_cs  <= 1'b0;
                            eep_di  <= 1'b0;
                            gapcnt  <= '0;
                            closing <= 1'b0;
                            state   <= prog_q ? S_GAP : S_FIN;
                        end else begin
                            eep_di <= frame_q[FW-1-int'(bitcnt)];
                        end
                    end
                end
                S_READ: begin
                    if (rise_en && !closing) begin
                        if (dummy) begin
                            dummy <= 1'b0;
                        end else begin
                            shreg <= {shreg[DW-2:0], eep_do};
                            if (rbit == RBW'(DW - 1)) begin
                                rbit     <= '0;
                                rd_valid <= 1'b1;
                                rd_data  <= {shreg[DW-2:0], eep_do};
                                if (words_left == WCW'(1)) closing <= 1'b1;
                                else words_left <= words_left - WCW'(1);
                            end else begin
                                rbit <= rbit + RBW'(1);
                            end
                        end
                    end
                    if (fall_en) begin
                        eep_di <= 1'b0;
                        if (closing) begin
                            eep_cs  <= 1'b0;
                            closing <= 1'b0;
                            state   <= S_FIN;
                        end
                    end
                end
                S_GAP: begin
                    if (gapcnt == GW'(CS_GAP - 1)) begin
                        eep_cs  <= 1'b1;
                        eep_di  <= 1'b0;
                        pollcnt <= '0;
                        state   <= S_POLL;
                    end else begin
                        gapcnt <= gapcnt + GW'(1);
                    end
                end
                S_POLL: begin
                    if (rise_en && !closing) begin
                        if (eep_do) begin
                            closing <= 1'b1;
                        end else if (pollcnt == PW'(POLL_LIMIT - 1)) begin
                            closing <= 1'b1;
                            err     <= 1'b1;
                        end else begin
                            pollcnt <= pollcnt + PW'(1);
                        end
                    end
                    if (fall_en && closing) begin
                        eep_cs  <= 1'b0;
                        closing <= 1'b0;
                        state   <= S_FIN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4
    sk_cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eep_cs |-> !eep_sk);

    // R4
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sk && $past(eep_sk)) |-> $stable(eep_di));

    // R7
    poll_di_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL) |-> !eep_di);

    // R9
    done_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !eep_cs);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    rdv_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> eep_cs);
endmodule

// File: tb/mwh_host_tb_top.sv
// Behavioural serial EEPROM used by the bench (128 x 16).
module mwh_eep_model (
    input  logic clk,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  int   busy_len,
    output logic dout
);
    logic [15:0] mem [128];
    logic        wen = 1'b0;
    logic        poll_mode = 1'b0;
    int          mode = 0;
    int          cnt = 0;
    int          pend = 0;
    int          cyc = 0;
    int          busy_end = 0;
    int          rpos = 0;
    logic [9:0]  hdr = '0;
    logic [9:0]  last_hdr = '0;
    logic [15:0] dsr = '0;
    logic [15:0] rword = '0;
    logic [6:0]  ra = '0;
    logic [6:0]  pa = '0;
    logic        rbit_o = 1'b0;

    initial for (int i = 0; i < 128; i++) mem[i] = 16'h1000 + 16'(i);

    always @(posedge clk) cyc <= cyc + 1;

    assign dout = (cs && mode == 3) ? rbit_o : (poll_mode ? (cyc >= busy_end) : 1'b0);

    always @(posedge sk) begin
        if (cs) begin
            case (mode)
                0: if (di) begin mode = 1; cnt = 0; poll_mode = 1'b0; end
                1: begin
                    hdr = {hdr[8:0], di};
                    cnt++;
                    if (cnt == 10) begin
                        last_hdr = hdr;
                        pa = hdr[6:0];
                        mode = 4;
                        case (hdr[9:8])
                            2'b10: begin mode = 3; ra = hdr[6:0]; rword = mem[ra]; rpos = 16; rbit_o = 1'b0; end
                            2'b01: begin pend = 1; mode = 2; cnt = 0; end
                            2'b11: pend = 2;
                            default: case (hdr[7:6])
                                2'b11: wen = 1'b1;
                                2'b00: wen = 1'b0;
                                2'b01: begin pend = 3; mode = 2; cnt = 0; end
                                default: pend = 4;
                            endcase
                        endcase
                    end
                end
                2: begin
                    dsr = {dsr[14:0], di};
                    cnt++;
                    if (cnt == 16) mode = 4;
                end
                3: begin
                    if (rpos == 0) begin ra = ra + 7'd1; rword = mem[ra]; rpos = 16; end
                    rbit_o = rword[rpos-1];
                    rpos--;
                end
                default: ;
            endcase
        end
    end

    always @(negedge cs) begin
        if (pend != 0 && mode == 4) begin
            if (wen) begin
                case (pend)
                    1: mem[pa] = dsr;
                    2: mem[pa] = 16'hFFFF;
                    3: for (int i = 0; i < 128; i++) mem[i] = dsr;
                    default: for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
                endcase
                busy_end = cyc + busy_len;
            end
            poll_mode = 1'b1;
        end
        pend = 0;
        mode = 0;
    end
endmodule

// Scoreboard bench for the serial EEPROM host sequencer.
module mwh_host_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int GAP = 6;
    localparam int PLIM = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  cmd_words = '0;
    logic        busy, done, err, rd_valid, eep_cs, eep_sk, eep_di, eep_do;
    logic [15:0] rd_data;
    int          busy_len = 100;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    logic [15:0] shadow [128];

    int cs_rises = 0, rdv_count = 0, last_gap = 0, low_run = 0;
    int sk_per = 0, sk_ctr = 0, done_max = 0, done_run = 0, sk_bad = 0;
    logic cs_prev = 1'b0, sk_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwh_host #(.SK_HALF(HALF), .CS_GAP(GAP), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_words(cmd_words),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di), .eep_do(eep_do)
    );

    mwh_eep_model dev_i (.clk(clk), .cs(eep_cs), .sk(eep_sk), .di(eep_di),
                         .busy_len(busy_len), .dout(eep_do));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pop and port observations, sampled at negedge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                rdv_count++;
                if (exp_q.size() == 0) check(0, "R5", "unexpected word", rd_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R5", "read word", rd_data, e);
                end
            end
            if (eep_cs && !cs_prev) begin cs_rises++; last_gap = low_run; end
            low_run = eep_cs ? 0 : low_run + 1;
            sk_ctr++;
            if (eep_sk && !sk_prev) begin
                if (eep_cs && sk_ctr < 100) sk_per = sk_ctr;
                sk_ctr = 0;
            end
            if (eep_sk && !eep_cs) sk_bad++;
            done_run = done ? done_run + 1 : 0;
            if (done_run > done_max) done_max = done_run;
        end
        cs_prev = eep_cs;
        sk_prev = eep_sk;
    end

    task automatic issue(input logic [2:0] op, input logic [6:0] a,
                         input logic [15:0] d, input logic [7:0] w);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_words = w;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [6:0] a,
                           input logic [15:0] d, input logic [7:0] w);
        cs_rises = 0;
        issue(op, a, d, w);
        wait_done();
    endtask

    task automatic do_read(input logic [6:0] a, input int w, input string req);
        int n;
        n = (w == 0) ? 1 : w;
        for (int i = 0; i < n; i++) exp_q.push_back(shadow[7'(a + 7'(i))]);
        rdv_count = 0;
        run_cmd(3'd0, a, 16'h0, 8'(w));
        check(exp_q.size() == 0 && rdv_count == n, req, "words delivered", rdv_count, n);
        check(cs_rises == 1, req, "single select window", cs_rises, 1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 16'h1000 + 16'(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        check({eep_cs, eep_sk, eep_di, busy, done, err, rd_valid} == 7'b0, "R1",
              "outputs in reset", {eep_cs, eep_sk, eep_di, busy, done, err, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({eep_cs, eep_sk, busy, done, err, rd_valid} == 6'b0, "R1",
              "outputs after reset", {eep_cs, eep_sk, busy, done, err, rd_valid}, 0);

        // R5 single read with dummy discard, R4 SK period
        do_read(7'd3, 1, "R5");
        check(sk_per == 2*HALF, "R4", "sk period", sk_per, 2*HALF);

        // R2 R11 enable writes: header only, no poll
        run_cmd(3'd3, 7'h55, 16'h0, 8'd0);
        check(dev_i.last_hdr == 10'b0011000000, "R2", "enable header", dev_i.last_hdr, 10'b0011000000);
        check(cs_rises == 1, "R11", "enable no poll", cs_rises, 1);

        // R3 R7 write word
        run_cmd(3'd1, 7'd5, 16'hA5C3, 8'd0);
        shadow[5] = 16'hA5C3;
        check(dev_i.last_hdr == 10'b0100000101, "R2", "write header", dev_i.last_hdr, 10'b0100000101);
        check(cs_rises == 2, "R7", "frame plus poll window", cs_rises, 2);
        check(last_gap >= GAP, "R7", "select low gap", last_gap, GAP);
        check(!err, "R7", "no error on ready", err, 0);
        do_read(7'd5, 1, "R3");

        // R9 start while busy ignored
        cs_rises = 0;
        issue(3'd1, 7'd9, 16'h1234, 8'd0);
        repeat (20) @(negedge clk);
        check(busy, "R9", "busy during write", busy, 1);
        cmd_op = 3'd6; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        shadow[9] = 16'h1234;
        do_read(7'd9, 2, "R9");

        // R7 erase word
        run_cmd(3'd2, 7'd7, 16'h0, 8'd0);
        shadow[7] = 16'hFFFF;
        do_read(7'd7, 1, "R7");

        // R11 disable writes then write is ignored
        run_cmd(3'd4, 7'd0, 16'h0, 8'd0);
        check(cs_rises == 1, "R11", "disable no poll", cs_rises, 1);
        run_cmd(3'd1, 7'd5, 16'h0000, 8'd0);
        do_read(7'd5, 1, "R11");

        // R6 burst with wrap, and count 0 means one word
        do_read(7'd125, 6, "R6");
        do_read(7'd2, 0, "R6");

        // R3 write-all, R7 erase-all
        run_cmd(3'd3, 7'd0, 16'h0, 8'd0);
        run_cmd(3'd5, 7'd0, 16'h5AA5, 8'd0);
        for (int i = 0; i < 128; i++) shadow[i] = 16'h5AA5;
        do_read(7'd0, 3, "R3");
        run_cmd(3'd6, 7'd0, 16'h0, 8'd0);
        for (int i = 0; i < 128; i++) shadow[i] = 16'hFFFF;
        do_read(7'd64, 2, "R7");

        // R10 rejected code
        run_cmd(3'd7, 7'd0, 16'h0, 8'd0);
        check(cs_rises == 0, "R10", "no select activity", cs_rises, 0);
        check(err, "R10", "error flag", err, 1);

        // R9 done pulse width, R4 sk never high with select low
        check(done_max == 1, "R9", "done width", done_max, 1);
        check(sk_bad == 0, "R4", "sk high with select low", sk_bad, 0);

        // R8 poll timeout then cleared by next command
        busy_len = 1000000;
        run_cmd(3'd1, 7'd20, 16'hBEEF, 8'd0);
        check(err, "R8", "timeout error", err, 1);
        repeat (10) @(negedge clk);
        check(err, "R8", "error held", err, 1);
        run_cmd(3'd3, 7'd0, 16'h0, 8'd0);
        check(!err, "R8", "error cleared", err, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule